// File: doc/BRIEF.md
# Banked Embedded-DRAM Refresh Scheduler

This block tracks which banks of a heavily banked embedded-DRAM cache are free to use. Each cycle it can accept one demand access, addressed by bank and row. An accepted access makes its bank unavailable for a fixed recovery time. In the same cycle the block can send one refresh to some other bank that is idle. Refresh moves through every row of every bank in a short sweep. Any row that a demand access reached during the current sweep has already had its charge restored, so that row is skipped. As a result, streaming traffic meets almost no refresh work.

A requester watches the per-bank ready vector. If its bank is busy, the grant stays low, and the requester holds the request until a grant is returned. The refresh outputs give the bank and row being refreshed in the current cycle. A pulse marks the end of each sweep. A sticky flag reports a sweep that runs past a deadline set on an input port.

Top module: `banked_refresh_sched`

## Requirements
- R1: While reset is active, and right after it, every bank reports ready, and the grant, refresh strobe, sweep pulse and overdue flag are all low.
- R2: `req_grant` is high in a cycle exactly when `req_valid` is high and the addressed bank reports ready. A request held through busy cycles is granted in the first cycle its bank is ready again.
- R3: After a demand or refresh to a bank is accepted, that bank's ready bit is low for exactly BUSY_CYCLES cycles and then returns high.
- R4: At most one refresh is issued per cycle. It goes only to a bank that is ready in that cycle and that is not being granted a demand access in the same cycle.
- R5: The refresh picker searches upward from the bank after the one it last refreshed, wrapping around. After reset, with no demand traffic, the first refreshes go to banks 0, 1, 2, 3 in that order.
- R6: Within one sweep, each bank's rows are refreshed in ascending order starting from row 0. Every row that was not skipped is refreshed exactly once.
- R7: A row that receives an accepted demand access during the current sweep, before the refresh walk reaches it, is not refreshed in that sweep.
- R8: All touched-row marks are cleared when a sweep completes, so rows skipped in one sweep are refreshed in the next.
- R9: `sweep_done` is a single-cycle pulse. It is raised once every bank has refreshed or skipped all its rows, and the next sweep starts in the following cycle.
- R10: `sweep_overdue` goes high if the cycle count since the sweep started reaches `sweep_deadline` before the sweep finishes. It stays high until the sweep ends, and it is low in the cycle after `sweep_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Demand access request |
| req_bank | input | $clog2(NUM_BANKS) | Bank of the demand access |
| req_row | input | $clog2(ROWS) | Row of the demand access |
| sweep_deadline | input | DL_W | Cycle limit for one sweep before the overdue flag is raised |
| req_grant | output | 1 | Demand access accepted this cycle |
| bank_ready | output | NUM_BANKS | One bit per bank, high when the bank is idle |
| ref_valid | output | 1 | A refresh is issued this cycle |
| ref_bank | output | $clog2(NUM_BANKS) | Bank being refreshed |
| ref_row | output | $clog2(ROWS) | Row being refreshed |
| sweep_done | output | 1 | Pulse when the current sweep completes |
| sweep_overdue | output | 1 | Sweep exceeded its deadline |

## Verification
The assertions check the following on every cycle:
- A loaded bank drops ready, and a bank is loaded only while it is ready.
- A refresh never lands on a busy bank or on the bank taking a demand access.
- A touched row is never chosen for refresh.
- A finished bank holds its pointer.
- The sweep pulse and the overdue flag both clear one cycle after completion.

Only the bench's scenarios can show the rest. These are the exact busy-window length, the rotation order of the picker, and the rule that each row is refreshed exactly once per sweep. They also cover the rows skipped after demand touches, the return of those rows in the next sweep, and an overdue flag raised by a short deadline.

// File: rtl/rfsh_sched_pkg.sv
package rfsh_sched_pkg;
  localparam int DEF_BANKS = 16;
  localparam int DEF_ROWS  = 128;
  localparam int DEF_BUSY  = 5;
  localparam int DEF_DL_W  = 16;

  // modular add for a rotating index, a and b both below n
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/rfsh_bank_timer.sv
module rfsh_bank_timer #(
  parameter int BUSY_CYCLES = rfsh_sched_pkg::DEF_BUSY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);

  // R3
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);

  // R3
  load_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ready);
endmodule

// File: rtl/rfsh_row_tracker.sv
module rfsh_row_tracker #(
  parameter int ROWS = rfsh_sched_pkg::DEF_ROWS,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          mark,
  input  logic [RW-1:0] mark_row,
  input  logic          advance_ref,
  output logic          done,
  output logic          skip,
  output logic [RW-1:0] row
);
  logic [ROWS-1:0] touched_q, touched_d;
  logic [RW-1:0]   ptr_q, ptr_d;
  logic            done_q, done_d;
  logic            adv;

  assign skip = !done_q && touched_q[ptr_q];
  assign adv  = !done_q && (advance_ref || touched_q[ptr_q]);
  assign done = done_q;
  assign row  = ptr_q;

  always_comb begin
    touched_d = clear ? '0 : touched_q;
    if (mark) touched_d[mark_row] = 1'b1;
    ptr_d  = ptr_q;
    done_d = done_q;
    if (clear) begin
      ptr_d  = '0;
      done_d = 1'b0;
    end else if (adv) begin
      if (ptr_q == RW'(ROWS - 1)) begin
        ptr_d  = '0;
        done_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched_q <= '0;
      ptr_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      touched_q <= touched_d;
      ptr_q     <= ptr_d;
      done_q    <= done_d;
    end
  end

  // R7
  no_ref_touched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !advance_ref);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> (done && $stable(row)));
endmodule

// File: rtl/rfsh_picker.sv
module rfsh_picker #(
  parameter int NB  = rfsh_sched_pkg::DEF_BANKS,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] elig,
  output logic          valid,
  output logic [BW-1:0] idx
);
  logic [BW-1:0] rp_q, rp_d;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < NB; i++) begin
      int c;
      c = rfsh_sched_pkg::wrap_add(int'(rp_q), i, NB);
      if (!valid && elig[c]) begin
        valid = 1'b1;
        idx   = BW'(c);
      end
    end
    rp_d = valid ? BW'(rfsh_sched_pkg::wrap_add(int'(idx), 1, NB)) : rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rp_q <= '0;
    else        rp_q <= rp_d;
  end

  // R4
  pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> elig[idx]);

  // R4
  idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !valid);
endmodule

// File: rtl/banked_refresh_sched.sv
module banked_refresh_sched #(
  parameter int NUM_BANKS   = rfsh_sched_pkg::DEF_BANKS,
  parameter int ROWS        = rfsh_sched_pkg::DEF_ROWS,
  parameter int BUSY_CYCLES = rfsh_sched_pkg::DEF_BUSY,
  parameter int DL_W        = rfsh_sched_pkg::DEF_DL_W,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [BW-1:0]        req_bank,
  input  logic [RW-1:0]        req_row,
  input  logic [DL_W-1:0]      sweep_deadline,
  output logic                 req_grant,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic                 ref_valid,
  output logic [BW-1:0]        ref_bank,
  output logic [RW-1:0]        ref_row,
  output logic                 sweep_done,
  output logic                 sweep_overdue
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [NUM_BANKS-1:0] demand_hit, ref_hit, bank_done, row_skip, elig, load;
  logic [RW-1:0]        row_ptr [NUM_BANKS];
  logic                 pick_valid;
  logic [BW-1:0]        pick_idx;

  assign req_grant = rst_int_n && req_valid && bank_ready[req_bank];
  assign ref_valid = rst_int_n && pick_valid;
  assign ref_bank  = pick_idx;
  assign ref_row   = row_ptr[pick_idx];
  assign sweep_done = &bank_done;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign demand_hit[b] = req_grant && (req_bank == BW'(b));
    assign ref_hit[b]    = ref_valid && (pick_idx == BW'(b));
    assign load[b]       = demand_hit[b] || ref_hit[b];
    assign elig[b]       = bank_ready[b] && !demand_hit[b] && !bank_done[b] && !row_skip[b];

    rfsh_bank_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_int_n),
      .load  (load[b]),
      .ready (bank_ready[b])
    );

    rfsh_row_tracker #(.ROWS(ROWS)) u_rows (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .clear       (sweep_done),
      .mark        (demand_hit[b]),
      .mark_row    (req_row),
      .advance_ref (ref_hit[b]),
      .done        (bank_done[b]),
      .skip        (row_skip[b]),
      .row         (row_ptr[b])
    );
  end

  rfsh_picker #(.NB(NUM_BANKS)) u_pick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .elig  (elig),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  // sweep age and deadline
  logic [DL_W-1:0] age_q, age_d;
  logic            late_q, late_d;

  always_comb begin
    age_d  = age_q;
    late_d = late_q;
    if (sweep_done) begin
      age_d  = '0;
      late_d = 1'b0;
    end else begin
      if (age_q != {DL_W{1'b1}}) age_d = age_q + 1'b1;
      if (age_q >= sweep_deadline) late_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      age_q  <= '0;
      late_q <= 1'b0;
    end else begin
      age_q  <= age_d;
      late_q <= late_d;
    end
  end

  assign sweep_overdue = late_q;

  // R4
  ref_conflict_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ref_valid |-> (bank_ready[ref_bank] && !(req_grant && req_bank == ref_bank)));

  // R9
  sweep_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sweep_done |=> !sweep_done);

  // R10
  overdue_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sweep_done |=> !sweep_overdue);
endmodule

// File: tb/tb_banked_refresh_sched.sv
module tb_banked_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int NR   = 8;
  localparam int BUSY = 5;
  localparam int DLW  = 16;
  localparam int BW   = $clog2(NB);
  localparam int RW   = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_row;
  logic [DLW-1:0] sweep_deadline;
  logic req_grant, ref_valid, sweep_done, sweep_overdue;
  logic [NB-1:0] bank_ready;
  logic [BW-1:0] ref_bank;
  logic [RW-1:0] ref_row;

  banked_refresh_sched #(.NUM_BANKS(NB), .ROWS(NR), .BUSY_CYCLES(BUSY), .DL_W(DLW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .sweep_deadline(sweep_deadline), .req_grant(req_grant),
    .bank_ready(bank_ready), .ref_valid(ref_valid), .ref_bank(ref_bank),
    .ref_row(ref_row), .sweep_done(sweep_done), .sweep_overdue(sweep_overdue)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  int cnt_live [NB][NR];
  int cnt_last [NB][NR];
  int last_row [NB];
  int first_bank [4];
  int nlog = 0;
  int conflict_err = 0, order_err = 0, pulse_err = 0;
  bit prev_done = 0, ov_seen = 0, ov_last = 0;

  initial begin
    for (int b = 0; b < NB; b++) begin
      last_row[b] = -1;
      for (int r = 0; r < NR; r++) begin
        cnt_live[b][r] = 0;
        cnt_last[b][r] = 0;
      end
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (ref_valid) begin
        if (!bank_ready[ref_bank] || (req_grant && req_bank == ref_bank)) conflict_err++;
        if (int'(ref_row) <= last_row[ref_bank]) order_err++;
        last_row[ref_bank] = int'(ref_row);
        cnt_live[ref_bank][ref_row]++;
        if (nlog < 4) begin
          first_bank[nlog] = int'(ref_bank);
          nlog++;
        end
      end
      if (sweep_overdue) ov_seen = 1;
      if (sweep_done) begin
        if (prev_done) pulse_err++;
        for (int b = 0; b < NB; b++) begin
          last_row[b] = -1;
          for (int r = 0; r < NR; r++) begin
            cnt_last[b][r] = cnt_live[b][r];
            cnt_live[b][r] = 0;
          end
        end
        ov_last = ov_seen;
        ov_seen = 0;
      end
      prev_done = sweep_done;
    end
  end

  task automatic wait_done();
    do begin
      @(negedge clk);
      #3;
    end while (!sweep_done);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD * 2 + 3);
    check(bank_ready == {NB{1'b1}}, "R1 ready", int'(bank_ready), (1 << NB) - 1);
    check(!sweep_done && !sweep_overdue, "R1 flags", int'({sweep_done, sweep_overdue}), 0);
    check(!ref_valid && !req_grant, "R1 strobes", int'({ref_valid, req_grant}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_full_sweep();
    int bad;
    wait_done();
    for (int i = 0; i < 4; i++)
      check(first_bank[i] == i, "R5 rotation", first_bank[i], i);
    bad = 0;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++)
        if (cnt_last[b][r] != 1) bad++;
    check(bad == 0, "R6 once per row", bad, 0);
    check(order_err == 0, "R6 ascending", order_err, 0);
    check(conflict_err == 0, "R4 no conflict", conflict_err, 0);
    check(!ov_last, "R10 no overdue", int'(ov_last), 0);
  endtask

  task automatic t_touch();
    int tb_[5] = '{0, 1, 2, 3, 1};
    int tr_[5] = '{7, 7, 7, 7, 6};
    int mism, bad;
    mism = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_bank  = BW'(tb_[k]);
      req_row   = RW'(tr_[k]);
      #3;
      if (req_grant != bank_ready[req_bank]) mism++;
      while (!req_grant) begin
        @(negedge clk);
        #3;
        if (req_grant != bank_ready[req_bank]) mism++;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(mism == 0, "R2 grant follows ready", mism, 0);
    wait_done();
    bad = 0;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        int exp;
        exp = (r == 7 || (b == 1 && r == 6)) ? 0 : 1;
        if (cnt_last[b][r] != exp) bad++;
      end
    check(bad == 0, "R7 touched rows skipped", bad, 0);
    check(cnt_last[1][6] == 0, "R7 bank1 row6", cnt_last[1][6], 0);
    check(pulse_err == 0, "R9 single pulse", pulse_err, 0);
  endtask

  task automatic t_busy();
    do begin
      @(negedge clk);
      #1;
    end while (!bank_ready[2]);
    req_valid = 1'b1;
    req_bank  = 2'd2;
    req_row   = 3'd0;
    #2;
    check(req_grant == 1'b1, "R2 grant ready bank", int'(req_grant), 1);
    for (int k = 1; k <= BUSY; k++) begin
      @(negedge clk);
      #3;
      check(!bank_ready[2] && !req_grant, "R3 busy window", int'({bank_ready[2], req_grant}), 0);
    end
    @(negedge clk);
    #3;
    check(bank_ready[2] && req_grant, "R3 ready after window", int'({bank_ready[2], req_grant}), 3);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    for (int b = 0; b < NB; b++)
      check(cnt_last[b][7] == 1, "R8 row7 back in sweep", cnt_last[b][7], 1);
  endtask

  task automatic t_overdue();
    sweep_deadline = 16'd3;
    wait_done();
    check(ov_last, "R10 overdue raised", int'(ov_last), 1);
    @(negedge clk);
    #3;
    check(!sweep_overdue, "R10 cleared after done", int'(sweep_overdue), 0);
    sweep_deadline = 16'd1000;
    check(conflict_err == 0 && pulse_err == 0, "R4 R9 final", conflict_err + pulse_err, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_bank = '0;
    req_row = '0;
    sweep_deadline = 16'd1000;
    t_reset();
    t_full_sweep();
    t_touch();
    t_busy();
    t_overdue();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule